// File: doc/BRIEF.md
# Four-Mode Carrier-Compare PWM Modulator

This block turns two duty commands into the switching sequence of a buck rectifier stage that has an active energy buffer. One command is the non-negative share of the period during which the source feeds the output directly. The other is a signed buffer term: a positive value asks the buffer capacitor to give up energy and a negative value asks it to take energy in. The block steers the buffer term into either a discharge slot or a charge slot and builds three cumulative compare levels from the duties. It compares those levels against one symmetric triangular carrier.

The three comparison results select one of four operating modes: direct supply, buffer discharge, buffer charge, and inductor freewheel. Because the levels are cumulative, the carrier always crosses a buffer slot between the direct and freewheel regions whenever the buffer term is non-zero. A small writable table maps the mode code to the two buffer switch enables. Every switch combination is a legal mode, so no dead-time or overlap time is inserted. Duty commands are sampled only at the carrier valley, so a command that arrives mid-period takes effect in the next period.

Top module: `fourmode_pwm`

## Requirements
- R1: After reset the carrier counts up by one per clock from 0 to PEAK = 2^CW − 1, then down by one per clock to 0, and repeats; it reverses at both ends, so a period is 2·PEAK clocks.
- R2: A latched buffer term that is zero or positive becomes the discharge duty and the charge duty is zero; a negative term makes the charge duty equal to its magnitude and the discharge duty zero.
- R3: The compare levels are L1 = direct duty, L2 = min(direct + discharge, PEAK) and L3 = min(direct + charge, PEAK); a comparison bit is 1 when the carrier is below its level, or whenever the level equals PEAK.
- R4: The mode output is combinational from the current carrier and the latched levels: code 0 (direct) if bit 1 is set, else code 1 (discharge) if bit 2 is set, else code 2 (charge) if bit 3 is set, else code 3 (freewheel).
- R5: Both duty inputs are captured on the clock edge at which the carrier is 0; changes at any other time have no effect on the mode or the saturation flag until that edge.
- R6: While the latched buffer term is non-zero, the mode never changes directly between code 0 and code 3 from one cycle to the next, except when leaving a cycle in which the carrier is 0.
- R7: The saturation flag is 1 for the whole period whose latched duties sum to more than PEAK, and 0 otherwise; in such a period the freewheel mode does not occur.
- R8: The gate output is registered: in each cycle it equals the table entry for the mode code of the previous cycle. Bit 0 enables the discharge switch and bit 1 enables the charge switch. After reset the table holds code 0 → 00, 1 → 01, 2 → 10, 3 → 00.
- R9: With the table write enable high, the table entry selected by the index is replaced by the write value at that clock edge, and gate outputs use it from the following edge onward.
- R10: A synchronous active-high reset sets the carrier to 0, clears the latched duties (so the mode is 3 and the flag is 0), clears both gates and restores the default table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_dir | input | CW | Direct-supply duty, fraction of PEAK |
| duty_buf | input | CW+1 | Signed buffer duty term, fraction of PEAK |
| tbl_we | input | 1 | Mode-to-gate table write enable |
| tbl_idx | input | 2 | Table entry (mode code) to write |
| tbl_val | input | 2 | Gate pattern to write |
| carrier_o | output | CW | Triangular carrier value |
| mode_o | output | 2 | Active mode code |
| gate_o | output | 2 | Buffer switch enables (bit 0 discharge, bit 1 charge) |
| sat_o | output | 1 | Latched duties exceed one period |

## Verification
A carrier that loses a step or turns at the wrong value shows on the carrier port in the same cycle and shifts every mode boundary after it. A wrong latched level or a buffer term routed into the wrong slot shifts a mode edge, which is seen on the mode port in the first period after the faulty capture, and on the gate port one clock after that. A corrupt table entry appears on the gates the first time that mode is entered. Reset is checked mid-period, so any state that survives it shows on the ports within a single period.

// File: rtl/fmpwm_pkg.sv
package fmpwm_pkg;

    typedef enum logic [1:0] {
        MODE_DIRECT = 2'd0,
        MODE_DISCH  = 2'd1,
        MODE_CHARGE = 2'd2,
        MODE_FREE   = 2'd3
    } fmpwm_mode_e;

    localparam int GATE_W = 2;
    localparam int MODES  = 4;
    localparam int NLVL   = 3;

    typedef logic [GATE_W-1:0] gate_t;

endpackage

// File: rtl/fmpwm_carrier.sv
module fmpwm_carrier #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] cnt_o,
    output logic          at_zero_o
);
    localparam logic [CW-1:0] PEAK    = '1;
    localparam logic [CW-1:0] PEAK_M1 = PEAK - 1'b1;
    localparam logic [CW-1:0] ONE     = {{(CW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          up;
    } car_st_t;

    car_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.up) begin
            if (st_q.cnt == PEAK) begin
                st_d.cnt = st_q.cnt - ONE;
                st_d.up  = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end else begin
            if (st_q.cnt == '0) begin
                st_d.cnt = st_q.cnt + ONE;
                st_d.up  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= '0;
            st_q.up  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign at_zero_o = (st_q.cnt == '0);

    AST_CARRIER_STEP: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(st_q.cnt) |=> ((st_q.cnt == $past(st_q.cnt) + ONE) || (st_q.cnt == $past(st_q.cnt) - ONE))); // R1
    AST_CARRIER_TOP_TURN: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == PEAK) |=> (st_q.cnt == PEAK_M1)); // R1

endmodule

// File: rtl/fmpwm_duty.sv
module fmpwm_duty
    import fmpwm_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cap_i,
    input  logic [CW-1:0]             dir_i,
    input  logic signed [CW:0]        buf_i,
    output logic [NLVL-1:0][CW-1:0]   lvl_o,
    output logic                      sat_o,
    output logic                      bnz_o
);
    localparam int            SW     = CW + 2;
    localparam logic [CW-1:0] PEAK   = '1;
    localparam logic [SW-1:0] PEAK_W = SW'(PEAK);

    typedef struct packed {
        logic [NLVL-1:0][CW-1:0] lvl;
        logic                    sat;
        logic                    bnz;
    } duty_st_t;

    duty_st_t st_d, st_q;

    logic          neg;
    logic [CW:0]   mag;
    logic [CW:0]   d_dis;
    logic [CW:0]   d_chg;
    logic [SW-1:0] sum_dis;
    logic [SW-1:0] sum_chg;
    logic [SW-1:0] sum_all;

    always_comb begin
        neg     = buf_i[CW];
        mag     = neg ? $unsigned(-buf_i) : $unsigned(buf_i);
        d_dis   = neg ? '0 : mag;
        d_chg   = neg ? mag : '0;
        sum_dis = SW'(dir_i) + SW'(d_dis);
        sum_chg = SW'(dir_i) + SW'(d_chg);
        sum_all = sum_dis + SW'(d_chg);

        st_d = st_q;
        if (cap_i) begin
            st_d.lvl[0] = dir_i;
            st_d.lvl[1] = (sum_dis > PEAK_W) ? PEAK : sum_dis[CW-1:0];
            st_d.lvl[2] = (sum_chg > PEAK_W) ? PEAK : sum_chg[CW-1:0];
            st_d.sat    = (sum_all > PEAK_W);
            st_d.bnz    = (mag != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.lvl;
    assign sat_o = st_q.sat;
    assign bnz_o = st_q.bnz;

    AST_HOLD_OFF_VALLEY: assert property (@(posedge clk) disable iff (rst)
        !cap_i |=> $stable(st_q)); // R5
    AST_ONE_BUFFER_SLOT: assert property (@(posedge clk) disable iff (rst)
        (st_q.lvl[1] == st_q.lvl[0]) || (st_q.lvl[2] == st_q.lvl[0])); // R2
    AST_SAT_FILLS_PERIOD: assert property (@(posedge clk) disable iff (rst)
        st_q.sat |-> ((st_q.lvl[1] == PEAK) || (st_q.lvl[2] == PEAK))); // R7

endmodule

// File: rtl/fmpwm_decode.sv
module fmpwm_decode
    import fmpwm_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic [CW-1:0]           cnt_i,
    input  logic [NLVL-1:0][CW-1:0] lvl_i,
    output fmpwm_mode_e             mode_o
);
    localparam logic [CW-1:0] PEAK = '1;

    logic [NLVL-1:0] hit;

    // R3: a level at the peak keeps its comparison true all period
    for (genvar k = 0; k < NLVL; k++) begin : g_cmp
        assign hit[k] = (cnt_i < lvl_i[k]) || (lvl_i[k] == PEAK);
    end

    // R4: priority decode of the three comparison bits
    always_comb begin
        if (hit[0])      mode_o = MODE_DIRECT;
        else if (hit[1]) mode_o = MODE_DISCH;
        else if (hit[2]) mode_o = MODE_CHARGE;
        else             mode_o = MODE_FREE;
    end

endmodule

// File: rtl/fmpwm_gates.sv
module fmpwm_gates
    import fmpwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  fmpwm_mode_e mode_i,
    input  logic        we_i,
    input  logic [1:0]  idx_i,
    input  gate_t       val_i,
    output gate_t       gate_o
);
    localparam logic [MODES-1:0][GATE_W-1:0] TBL_RST = {2'b00, 2'b10, 2'b01, 2'b00};

    typedef struct packed {
        logic [MODES-1:0][GATE_W-1:0] tbl;
        gate_t                        gate;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.gate = st_q.tbl[mode_i];
        if (we_i) begin
            st_d.tbl[idx_i] = val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.tbl  <= TBL_RST;
            st_q.gate <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o = st_q.gate;

    AST_GATES_OFF_IN_RESET: assert property (@(posedge clk)
        rst |=> (st_q.gate == '0)); // R10

endmodule

// File: rtl/fourmode_pwm.sv
module fourmode_pwm
    import fmpwm_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     duty_dir,
    input  logic signed [CW:0] duty_buf,
    input  logic              tbl_we,
    input  logic [1:0]        tbl_idx,
    input  logic [1:0]        tbl_val,
    output logic [CW-1:0]     carrier_o,
    output logic [1:0]        mode_o,
    output logic [1:0]        gate_o,
    output logic              sat_o
);
    logic [CW-1:0]           cnt;
    logic                    at_zero;
    logic [NLVL-1:0][CW-1:0] lvl;
    logic                    bnz;
    fmpwm_mode_e             mode;
    gate_t                   gate;

    fmpwm_carrier #(.CW(CW)) u_carrier (
        .clk       (clk),
        .rst       (rst),
        .cnt_o     (cnt),
        .at_zero_o (at_zero)
    );

    fmpwm_duty #(.CW(CW)) u_duty (
        .clk   (clk),
        .rst   (rst),
        .cap_i (at_zero),
        .dir_i (duty_dir),
        .buf_i (duty_buf),
        .lvl_o (lvl),
        .sat_o (sat_o),
        .bnz_o (bnz)
    );

    fmpwm_decode #(.CW(CW)) u_decode (
        .cnt_i  (cnt),
        .lvl_i  (lvl),
        .mode_o (mode)
    );

    fmpwm_gates u_gates (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode),
        .we_i   (tbl_we),
        .idx_i  (tbl_idx),
        .val_i  (tbl_val),
        .gate_o (gate)
    );

    assign carrier_o = cnt;
    assign mode_o    = mode;
    assign gate_o    = gate;

    AST_NO_DIRECT_TO_FREE: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DIRECT && bnz && !at_zero) |=> (mode != MODE_FREE)); // R6
    AST_NO_FREE_TO_DIRECT: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FREE && bnz && !at_zero) |=> (mode != MODE_DIRECT)); // R6
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (mode == MODE_FREE && cnt == '0 && !sat_o)); // R10

endmodule

// File: tb/tb_fourmode_pwm.sv
`timescale 1ns/1ps
module tb_fourmode_pwm;
    localparam int CW   = 12;
    localparam int PEAK = 4095;
    localparam int NV   = 8;
    // stimulus (direct duty, buffer term) and expected saturation flag
    localparam int VD1[NV]  = '{1000, 1500, 0,   2000, 3000, 4095, 2000,  0};
    localparam int VBF[NV]  = '{500,  -700, 300, 0,    2000, -10,  -2095, -4096};
    localparam int VSAT[NV] = '{0,    0,    0,   0,    1,    1,    0,     1};

    localparam int C_CAR = 0, C_MODE = 1, C_GATE = 2, C_SAT = 3, C_SEQ = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [CW-1:0]     duty_dir = '0;
    logic signed [CW:0] duty_buf = '0;
    logic              tbl_we = 1'b0;
    logic [1:0]        tbl_idx = '0;
    logic [1:0]        tbl_val = '0;
    logic [CW-1:0]     carrier_o;
    logic [1:0]        mode_o;
    logic [1:0]        gate_o;
    logic              sat_o;

    fourmode_pwm #(.CW(CW)) dut (
        .clk(clk), .rst(rst), .duty_dir(duty_dir), .duty_buf(duty_buf),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_val(tbl_val),
        .carrier_o(carrier_o), .mode_o(mode_o), .gate_o(gate_o), .sat_o(sat_o)
    );

    always #2 clk = ~clk;

    int n_run = 0;
    int n_fail = 0;
    int mc, mup, ml1, ml2, ml3, msat, mbnz, gexp, prev_mode, prev_c;
    int mtbl[4];
    bit latched_now;
    int err[5];
    int fa[5];
    int fe[5];

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic note(input int k, input int act, input int exp);
        if (err[k] == 0) begin
            fa[k] = act;
            fe[k] = exp;
        end
        err[k]++;
    endtask

    task automatic clear_errs();
        for (int k = 0; k < 5; k++) begin
            err[k] = 0; fa[k] = 0; fe[k] = 0;
        end
    endtask

    task automatic flush(input int k, input string req);
        chk(err[k] == 0, req, fa[k], fe[k]);
    endtask

    task automatic model_reset();
        mc = 0; mup = 1; ml1 = 0; ml2 = 0; ml3 = 0; msat = 0; mbnz = 0;
        gexp = 0; prev_mode = 3; prev_c = 0;
        mtbl[0] = 0; mtbl[1] = 1; mtbl[2] = 2; mtbl[3] = 0;
    endtask

    function automatic int exp_mode(input int c);
        bit s1, s2, s3;
        s1 = (c < ml1) || (ml1 == PEAK);
        s2 = (c < ml2) || (ml2 == PEAK);
        s3 = (c < ml3) || (ml3 == PEAK);
        if (s1) return 0;
        if (s2) return 1;
        if (s3) return 2;
        return 3;
    endfunction

    task automatic step();
        int em, d1, b, d2, d3;
        @(posedge clk);
        if (rst) begin
            model_reset();
        end else begin
            gexp = mtbl[prev_mode];
            if (tbl_we) mtbl[tbl_idx] = int'(tbl_val);
            if (mc == 0) begin
                d1 = int'(duty_dir);
                b  = int'(duty_buf);
                d2 = (b >= 0) ? b : 0;
                d3 = (b < 0) ? -b : 0;
                ml1 = d1;
                ml2 = (d1 + d2 > PEAK) ? PEAK : d1 + d2;
                ml3 = (d1 + d3 > PEAK) ? PEAK : d1 + d3;
                msat = (d1 + d2 + d3 > PEAK) ? 1 : 0;
                mbnz = (b != 0) ? 1 : 0;
                latched_now = 1'b1;
            end
            if (mup != 0) begin
                if (mc == PEAK) begin mc--; mup = 0; end else mc++;
            end else begin
                if (mc == 0) begin mc++; mup = 1; end else mc--;
            end
        end
        @(negedge clk);
        em = exp_mode(mc);
        if (int'(carrier_o) != mc) note(C_CAR, int'(carrier_o), mc);
        if (int'(mode_o) != em) note(C_MODE, int'(mode_o), em);
        if (int'(gate_o) != gexp) note(C_GATE, int'(gate_o), gexp);
        if (int'(sat_o) != msat) note(C_SAT, int'(sat_o), msat);
        if (mbnz != 0 && prev_c != 0 &&
            ((prev_mode == 0 && int'(mode_o) == 3) || (prev_mode == 3 && int'(mode_o) == 0)))
            note(C_SEQ, int'(mode_o), prev_mode);
        prev_mode = em;
        prev_c = mc;
    endtask

    task automatic run_vec(input int d1, input int b);
        duty_dir = d1[CW-1:0];
        duty_buf = b[CW:0];
        latched_now = 1'b0;
        while (!latched_now) step();
        repeat (2 * PEAK - 1) step();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "R1 watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        clear_errs();
        model_reset();
        // R10: state held by reset
        repeat (4) @(negedge clk);
        chk(carrier_o == '0, "R10 carrier in reset", int'(carrier_o), 0);
        chk(mode_o == 2'd3, "R10 mode in reset", int'(mode_o), 3);
        chk(gate_o == 2'd0, "R10 gates in reset", int'(gate_o), 0);
        chk(sat_o == 1'b0, "R10 flag in reset", int'(sat_o), 0);
        rst = 1'b0;

        // vector table: one full period per entry
        for (int v = 0; v < NV; v++) begin
            clear_errs();
            run_vec(VD1[v], VBF[v]);
            flush(C_CAR, "R1 carrier sequence");
            flush(C_MODE, "R2 R3 R4 mode per cycle");
            flush(C_GATE, "R8 registered gate map");
            flush(C_SAT, "R7 flag per cycle");
            flush(C_SEQ, "R6 direct/freewheel adjacency");
            chk(int'(sat_o) == VSAT[v], "R7 flag vs table", int'(sat_o), VSAT[v]);
        end

        // R5: mid-period command change is deferred to the valley
        clear_errs();
        duty_dir = 12'd1000;
        duty_buf = 13'sd500;
        latched_now = 1'b0;
        while (!latched_now) step();
        repeat (1999) step();
        duty_dir = 12'd3500;
        duty_buf = -13'sd200;
        step();
        chk(mode_o == 2'd3, "R5 old levels kept mid-period", int'(mode_o), 3);
        chk(sat_o == 1'b0, "R5 flag kept mid-period", int'(sat_o), 0);
        latched_now = 1'b0;
        while (!latched_now) step();
        repeat (2 * PEAK - 1) step();
        flush(C_MODE, "R5 mode across deferred capture");
        flush(C_SAT, "R5 flag across deferred capture");

        // R9: rewrite two table entries
        clear_errs();
        tbl_we = 1'b1; tbl_idx = 2'd3; tbl_val = 2'b11;
        step();
        tbl_idx = 2'd0; tbl_val = 2'b10;
        step();
        tbl_we = 1'b0;
        run_vec(1200, -600);
        flush(C_GATE, "R9 gates follow rewritten table");
        chk(gate_o == 2'b10, "R9 rewritten direct entry", int'(gate_o), 2);

        // R10: reset mid-period restores everything
        clear_errs();
        duty_dir = 12'd3000;
        duty_buf = 13'sd2000;
        latched_now = 1'b0;
        while (!latched_now) step();
        repeat (500) step();
        rst = 1'b1;
        step();
        step();
        chk(carrier_o == '0, "R10 carrier after mid reset", int'(carrier_o), 0);
        chk(mode_o == 2'd3, "R10 mode after mid reset", int'(mode_o), 3);
        chk(gate_o == 2'd0, "R10 gates after mid reset", int'(gate_o), 0);
        chk(sat_o == 1'b0, "R10 flag after mid reset", int'(sat_o), 0);
        rst = 1'b0;
        clear_errs();
        run_vec(1200, 700);
        flush(C_GATE, "R10 default table restored");
        flush(C_MODE, "R10 mode after restart");
        flush(C_CAR, "R10 carrier after restart");

        summary();
        $finish;
    end

endmodule